// File: doc/BRIEF.md
# Memory-Reference Queue Entry Sequencer

This block holds a ring of in-flight memory references (loads and stores). Each slot in the ring has its own small state machine. A slot receives its virtual address from address generation, gets it translated, waits until its ordering dependencies are resolved, and then competes for the data cache. If the access misses, the slot parks until a wake-up bit releases it. A load that hits keeps the returned data and then competes for the result bus. Slots are filled at the head of the ring, up to `ALLOC_W` per clock, and are released one per clock at the tail once they have finished.

There are three points where slots compete: translation, cache access and write-back. At each of them a rotating selector starts its search at the tail pointer, so the request it grants always comes from the oldest eligible slot. One vector input can return any number of parked slots to the cache-eligible state in a single clock. A later address write to an unfinished slot restarts it from translation, which is how a reference is replayed. `DEPTH` must be a power of two.

Top module: `lsq_seq`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `head_o` and `tail_o` are 0, `xl_req`, `mem_req` and `wb_req` are 0, and `alloc_ok` is 1 for any `alloc_cnt` from 0 to `ALLOC_W`.
- R2: `alloc_ok` is 1 exactly when `alloc_cnt` is no greater than `ALLOC_W` and no greater than the number of free slots. A request is taken whole or refused whole. When it is taken, slot `(head_o+k) mod DEPTH` receives `alloc_is_store[k]` and `alloc_sdata[k*DATA_W +: DATA_W]` for each k below `alloc_cnt`, and `head_o` advances by `alloc_cnt`.
- R3: `retire_vld` frees the slot at `tail_o` and advances `tail_o` by one only when that slot is complete or in the error state. In every other case it has no effect.
- R4: An `agen_vld` write to a slot that is allocated and neither complete nor in error stores `agen_va` and puts the slot in the translation-requesting state. This write takes precedence over every other event for that slot in the same clock. A write to a free, complete or error slot is ignored.
- R5: `xl_req` is 1 when any slot is requesting translation. `xl_idx` then names the first such slot counting up from `tail_o` (modulo `DEPTH`), and `xl_va` is that slot's address. Both are 0 when no slot is requesting. When `xl_gnt` is 1, the named slot moves to awaiting a translation response.
- R6: A translation response (`xl_rsp_vld`, `xl_rsp_idx`) to a slot that is awaiting one does one of two things. A nonzero `xl_rsp_err` sends the slot to the error state. Otherwise the slot stores `xl_rsp_pa0`, `xl_rsp_pa1` and `xl_rsp_split` and becomes PA-ready. A response to a slot in any other state is ignored.
- R7: A PA-ready slot whose `dep_clr` bit is 1 becomes cache-eligible at the next clock. While the bit is 0 it stays PA-ready.
- R8: `mem_req` is 1 when any slot is cache-eligible. The oldest such slot (counting from `tail_o`) is presented: `mem_tag` is one-hot with that slot's index as the set bit, `mem_pa0`, `mem_pa1`, `mem_split` and `mem_store` come from that slot, and `mem_wdata` is the slot's store data for a store and 0 for a load. All of these outputs are 0 when no slot is eligible. When `mem_gnt` is 1, the slot moves to in-flight.
- R9: A cache response (`mem_rsp_vld`, `mem_rsp_idx`) to an in-flight slot does one of three things. A miss (`mem_rsp_hit`=0) parks the slot. A store hit completes the slot. A load hit stores `mem_rsp_data` in the slot and makes it data-valid. A response to a slot in any other state is ignored.
- R10: In one clock, every parked slot whose `wake` bit is 1 returns to cache-eligible. `wake` bits for slots in other states have no effect.
- R11: `wb_req` is 1 when any slot is data-valid. `wb_idx` is the oldest such slot counting from `tail_o`, and `wb_data` is its load data. Both are 0 when no slot is data-valid. When `wb_gnt` is 1, that slot becomes complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_cnt | input | ACW | Number of slots requested this clock |
| alloc_is_store | input | ALLOC_W | Store flag per requested slot |
| alloc_sdata | input | ALLOC_W*DATA_W | Store data per requested slot |
| alloc_ok | output | 1 | The whole request is accepted |
| head_o | output | IW | Next slot to be filled |
| tail_o | output | IW | Oldest occupied slot |
| agen_vld | input | 1 | Address-generation result valid |
| agen_idx | input | IW | Slot receiving the address |
| agen_va | input | VA_W | Virtual address |
| xl_req | output | 1 | A slot requests translation |
| xl_gnt | input | 1 | Translation request accepted |
| xl_idx | output | IW | Slot presented for translation |
| xl_va | output | VA_W | Its virtual address |
| xl_rsp_vld | input | 1 | Translation response valid |
| xl_rsp_idx | input | IW | Slot the response belongs to |
| xl_rsp_err | input | ERR_W | Error code, 0 when translation succeeded |
| xl_rsp_pa0 | input | PA_W | First physical address |
| xl_rsp_pa1 | input | PA_W | Second physical address for a page-crossing access |
| xl_rsp_split | input | 1 | Access crosses a page |
| dep_clr | input | DEPTH | Per-slot flag: no older unresolved ancestors |
| mem_req | output | 1 | A slot requests the cache |
| mem_gnt | input | 1 | Cache request accepted |
| mem_tag | output | DEPTH | One-hot source slot |
| mem_pa0 | output | PA_W | First physical address |
| mem_pa1 | output | PA_W | Second physical address |
| mem_split | output | 1 | Page-crossing flag |
| mem_store | output | 1 | Access is a store |
| mem_wdata | output | DATA_W | Store data, 0 for loads |
| mem_rsp_vld | input | 1 | Cache response valid |
| mem_rsp_idx | input | IW | Slot the response belongs to |
| mem_rsp_hit | input | 1 | 1 for a hit, 0 for a miss |
| mem_rsp_data | input | DATA_W | Load data on a hit |
| wake | input | DEPTH | Per-slot release of parked slots |
| wb_req | output | 1 | A slot requests the result bus |
| wb_gnt | input | 1 | Result bus granted |
| wb_idx | output | IW | Slot presented for write-back |
| wb_data | output | DATA_W | Its load data |
| retire_vld | input | 1 | Retire the slot at the tail if it is finished |

## Verification
The hardest state to reach from the ports is a ring holding many slots parked on misses at the same moment, with several of them then released by one wake vector while others sit in unrelated states and their wake bits must be ignored. The stimulus reaches it by answering in-flight requests with a miss about half the time and keeping the wake vector sparse for long stretches. Every few dozen clocks it sends an all-ones burst. Meanwhile the allocation requests keep the ring near full, so the head wraps past the tail and the oldest-first choice is exercised across the wrap point. Random replay writes and error responses arrive throughout the run.

// File: rtl/lsq_pkg.sv
`timescale 1ns/1ps
package lsq_pkg;

  typedef enum logic [3:0] {
    E_FREE,
    E_AGEN,
    E_VARDY,
    E_XLATE,
    E_PARDY,
    E_MEMOK,
    E_INFLT,
    E_MISS,
    E_DATA,
    E_DONE,
    E_ERR
  } ent_st_e;

endpackage

// File: rtl/lsq_age_pick.sv
`timescale 1ns/1ps
// Rotating oldest-first selector: the search begins at base_i and wraps.
module lsq_age_pick #(
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] req_i,
  input  logic [IW-1:0]    base_i,
  output logic             vld_o,
  output logic [IW-1:0]    idx_o
);

  logic [IW-1:0] probe;

  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    probe = '0;
    for (int k = 0; k < DEPTH; k++) begin
      probe = base_i + IW'(k);
      if (!vld_o && req_i[probe]) begin
        vld_o = 1'b1;
        idx_o = probe;
      end
    end
  end

endmodule

// File: rtl/lsq_ring.sv
`timescale 1ns/1ps
// Head, tail and occupancy of the ring.
module lsq_ring #(
  parameter int DEPTH   = 16,
  parameter int ALLOC_W = 2,
  localparam int IW  = $clog2(DEPTH),
  localparam int CW  = IW + 1,
  localparam int ACW = $clog2(ALLOC_W + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [ACW-1:0] alloc_cnt_i,
  input  logic           retire_i,
  input  logic           tail_done_i,
  output logic           alloc_ok_o,
  output logic           ret_fire_o,
  output logic [IW-1:0]  head_o,
  output logic [IW-1:0]  tail_o
);

  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [IW-1:0] head_q, head_d, tail_q, tail_d;
  logic [CW-1:0] used_q, used_d, room, want, take;
  logic          in_range;

  always_comb begin
    room     = FULL - used_q;
    want     = CW'(alloc_cnt_i);
    in_range = alloc_cnt_i <= ACW'(ALLOC_W);
    alloc_ok_o = in_range && (want <= room);
    take       = alloc_ok_o ? want : '0;
    ret_fire_o = retire_i && tail_done_i;
    head_d = head_q + IW'(take);
    tail_d = tail_q + IW'(ret_fire_o);
    used_d = used_q + take - CW'(ret_fire_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      used_q <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      used_q <= used_d;
    end
  end

  assign head_o = head_q;
  assign tail_o = tail_q;

endmodule

// File: rtl/lsq_entry.sv
`timescale 1ns/1ps
// State machine and payload of one slot.
module lsq_entry
  import lsq_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic              alloc_st_i,
  input  logic [DATA_W-1:0] alloc_data_i,
  input  logic              free_i,
  input  logic              agen_i,
  input  logic [VA_W-1:0]   agen_va_i,
  input  logic              xl_go_i,
  input  logic              xl_rsp_i,
  input  logic              xl_err_i,
  input  logic [PA_W-1:0]   xl_pa0_i,
  input  logic [PA_W-1:0]   xl_pa1_i,
  input  logic              xl_split_i,
  input  logic              dep_ok_i,
  input  logic              mem_go_i,
  input  logic              mem_rsp_i,
  input  logic              mem_hit_i,
  input  logic [DATA_W-1:0] mem_data_i,
  input  logic              wake_i,
  input  logic              wb_go_i,
  output ent_st_e           st_o,
  output logic [VA_W-1:0]   va_o,
  output logic [PA_W-1:0]   pa0_o,
  output logic [PA_W-1:0]   pa1_o,
  output logic              split_o,
  output logic              store_o,
  output logic [DATA_W-1:0] data_o
);

  ent_st_e           st_q, st_d;
  logic              live, do_alloc, do_agen, do_pa, do_load;
  logic [VA_W-1:0]   va_q;
  logic [PA_W-1:0]   pa0_q, pa1_q;
  logic              split_q, store_q;
  logic [DATA_W-1:0] data_q;

  always_comb begin
    live     = !(st_q inside {E_FREE, E_DONE, E_ERR});
    do_alloc = alloc_i && (st_q == E_FREE);
    do_agen  = agen_i && live;
    do_pa    = 1'b0;
    do_load  = 1'b0;
    st_d     = st_q;
    if (do_alloc) begin
      st_d = E_AGEN;
    end else if (free_i && (st_q inside {E_DONE, E_ERR})) begin
      st_d = E_FREE;
    end else if (do_agen) begin
      st_d = E_VARDY;
    end else begin
      case (st_q)
        E_VARDY: if (xl_go_i) st_d = E_XLATE;
        E_XLATE: begin
          if (xl_rsp_i) begin
            if (xl_err_i) begin
              st_d = E_ERR;
            end else begin
              st_d  = E_PARDY;
              do_pa = 1'b1;
            end
          end
        end
        E_PARDY: if (dep_ok_i) st_d = E_MEMOK;
        E_MEMOK: if (mem_go_i) st_d = E_INFLT;
        E_INFLT: begin
          if (mem_rsp_i) begin
            if (!mem_hit_i) begin
              st_d = E_MISS;
            end else if (store_q) begin
              st_d = E_DONE;
            end else begin
              st_d    = E_DATA;
              do_load = 1'b1;
            end
          end
        end
        E_MISS:  if (wake_i) st_d = E_MEMOK;
        E_DATA:  if (wb_go_i) st_d = E_DONE;
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= E_FREE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (do_alloc) store_q <= alloc_st_i;
    if (do_agen)  va_q    <= agen_va_i;
    if (do_pa) begin
      pa0_q   <= xl_pa0_i;
      pa1_q   <= xl_pa1_i;
      split_q <= xl_split_i;
    end
    if (do_alloc)     data_q <= alloc_data_i;
    else if (do_load) data_q <= mem_data_i;
  end

  assign st_o    = st_q;
  assign va_o    = va_q;
  assign pa0_o   = pa0_q;
  assign pa1_o   = pa1_q;
  assign split_o = split_q;
  assign store_o = store_q;
  assign data_o  = data_q;

endmodule

// File: rtl/lsq_seq.sv
`timescale 1ns/1ps
module lsq_seq
  import lsq_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int ALLOC_W = 2,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int DATA_W  = 32,
  parameter int ERR_W   = 3,
  localparam int IW  = $clog2(DEPTH),
  localparam int ACW = $clog2(ALLOC_W + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ACW-1:0]            alloc_cnt,
  input  logic [ALLOC_W-1:0]        alloc_is_store,
  input  logic [ALLOC_W*DATA_W-1:0] alloc_sdata,
  output logic                      alloc_ok,
  output logic [IW-1:0]             head_o,
  output logic [IW-1:0]             tail_o,
  input  logic                      agen_vld,
  input  logic [IW-1:0]             agen_idx,
  input  logic [VA_W-1:0]           agen_va,
  output logic                      xl_req,
  input  logic                      xl_gnt,
  output logic [IW-1:0]             xl_idx,
  output logic [VA_W-1:0]           xl_va,
  input  logic                      xl_rsp_vld,
  input  logic [IW-1:0]             xl_rsp_idx,
  input  logic [ERR_W-1:0]          xl_rsp_err,
  input  logic [PA_W-1:0]           xl_rsp_pa0,
  input  logic [PA_W-1:0]           xl_rsp_pa1,
  input  logic                      xl_rsp_split,
  input  logic [DEPTH-1:0]          dep_clr,
  output logic                      mem_req,
  input  logic                      mem_gnt,
  output logic [DEPTH-1:0]          mem_tag,
  output logic [PA_W-1:0]           mem_pa0,
  output logic [PA_W-1:0]           mem_pa1,
  output logic                      mem_split,
  output logic                      mem_store,
  output logic [DATA_W-1:0]         mem_wdata,
  input  logic                      mem_rsp_vld,
  input  logic [IW-1:0]             mem_rsp_idx,
  input  logic                      mem_rsp_hit,
  input  logic [DATA_W-1:0]         mem_rsp_data,
  input  logic [DEPTH-1:0]          wake,
  output logic                      wb_req,
  input  logic                      wb_gnt,
  output logic [IW-1:0]             wb_idx,
  output logic [DATA_W-1:0]         wb_data,
  input  logic                      retire_vld
);

  localparam int CW = IW + 1;

  ent_st_e           e_st    [DEPTH];
  logic [VA_W-1:0]   e_va    [DEPTH];
  logic [PA_W-1:0]   e_pa0   [DEPTH];
  logic [PA_W-1:0]   e_pa1   [DEPTH];
  logic              e_split [DEPTH];
  logic              e_store [DEPTH];
  logic [DATA_W-1:0] e_data  [DEPTH];

  logic [DEPTH-1:0] xl_rq, mem_rq, wb_rq;
  logic             xl_vld, mem_vld, wb_vld;
  logic [IW-1:0]    xl_sel, mem_sel, wb_sel;
  logic             ret_fire, tail_done, xl_err_any;
  logic [IW-1:0]    head_w, tail_w;

  assign tail_done  = e_st[tail_w] inside {E_DONE, E_ERR};
  assign xl_err_any = |xl_rsp_err;

  lsq_ring #(.DEPTH(DEPTH), .ALLOC_W(ALLOC_W)) u_ring (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_cnt_i (alloc_cnt),
    .retire_i    (retire_vld),
    .tail_done_i (tail_done),
    .alloc_ok_o  (alloc_ok),
    .ret_fire_o  (ret_fire),
    .head_o      (head_w),
    .tail_o      (tail_w)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [IW-1:0]     off;
    logic              a_hit, a_st;
    logic [DATA_W-1:0] a_dat;

    assign off   = IW'(i) - head_w;
    assign a_hit = alloc_ok && (CW'(off) < CW'(alloc_cnt));

    always_comb begin
      a_dat = '0;
      a_st  = 1'b0;
      for (int s = 0; s < ALLOC_W; s++) begin
        if (off == IW'(s)) begin
          a_dat = alloc_sdata[s*DATA_W +: DATA_W];
          a_st  = alloc_is_store[s];
        end
      end
    end

    lsq_entry #(.VA_W(VA_W), .PA_W(PA_W), .DATA_W(DATA_W)) u_ent (
      .clk          (clk),
      .rst_n        (rst_n),
      .alloc_i      (a_hit),
      .alloc_st_i   (a_st),
      .alloc_data_i (a_dat),
      .free_i       (ret_fire && (tail_w == IW'(i))),
      .agen_i       (agen_vld && (agen_idx == IW'(i))),
      .agen_va_i    (agen_va),
      .xl_go_i      (xl_vld && xl_gnt && (xl_sel == IW'(i))),
      .xl_rsp_i     (xl_rsp_vld && (xl_rsp_idx == IW'(i))),
      .xl_err_i     (xl_err_any),
      .xl_pa0_i     (xl_rsp_pa0),
      .xl_pa1_i     (xl_rsp_pa1),
      .xl_split_i   (xl_rsp_split),
      .dep_ok_i     (dep_clr[i]),
      .mem_go_i     (mem_vld && mem_gnt && (mem_sel == IW'(i))),
      .mem_rsp_i    (mem_rsp_vld && (mem_rsp_idx == IW'(i))),
      .mem_hit_i    (mem_rsp_hit),
      .mem_data_i   (mem_rsp_data),
      .wake_i       (wake[i]),
      .wb_go_i      (wb_vld && wb_gnt && (wb_sel == IW'(i))),
      .st_o         (e_st[i]),
      .va_o         (e_va[i]),
      .pa0_o        (e_pa0[i]),
      .pa1_o        (e_pa1[i]),
      .split_o      (e_split[i]),
      .store_o      (e_store[i]),
      .data_o       (e_data[i])
    );

    assign xl_rq[i]  = e_st[i] == E_VARDY;
    assign mem_rq[i] = e_st[i] == E_MEMOK;
    assign wb_rq[i]  = e_st[i] == E_DATA;
  end

  lsq_age_pick #(.DEPTH(DEPTH)) u_pick_xl (
    .req_i (xl_rq), .base_i (tail_w), .vld_o (xl_vld), .idx_o (xl_sel)
  );
  lsq_age_pick #(.DEPTH(DEPTH)) u_pick_mem (
    .req_i (mem_rq), .base_i (tail_w), .vld_o (mem_vld), .idx_o (mem_sel)
  );
  lsq_age_pick #(.DEPTH(DEPTH)) u_pick_wb (
    .req_i (wb_rq), .base_i (tail_w), .vld_o (wb_vld), .idx_o (wb_sel)
  );

  assign head_o = head_w;
  assign tail_o = tail_w;

  assign xl_req = xl_vld;
  assign xl_idx = xl_sel;
  assign xl_va  = xl_vld ? e_va[xl_sel] : '0;

  assign mem_req   = mem_vld;
  assign mem_tag   = mem_vld ? (DEPTH'(1) << mem_sel) : '0;
  assign mem_pa0   = mem_vld ? e_pa0[mem_sel] : '0;
  assign mem_pa1   = mem_vld ? e_pa1[mem_sel] : '0;
  assign mem_split = mem_vld && e_split[mem_sel];
  assign mem_store = mem_vld && e_store[mem_sel];
  assign mem_wdata = mem_store ? e_data[mem_sel] : '0;

  assign wb_req  = wb_vld;
  assign wb_idx  = wb_sel;
  assign wb_data = wb_vld ? e_data[wb_sel] : '0;

endmodule

// File: rtl/lsq_seq_chk.sv
`timescale 1ns/1ps
module lsq_seq_chk #(
  parameter int DEPTH   = 16,
  parameter int ALLOC_W = 2,
  localparam int IW  = $clog2(DEPTH),
  localparam int ACW = $clog2(ALLOC_W + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [ACW-1:0]   alloc_cnt,
  input logic             alloc_ok,
  input logic [IW-1:0]    head_o,
  input logic [IW-1:0]    tail_o,
  input logic             retire_vld,
  input logic             agen_vld,
  input logic             xl_req,
  input logic             xl_gnt,
  input logic [IW-1:0]    xl_idx,
  input logic             mem_req,
  input logic [DEPTH-1:0] mem_tag,
  input logic             wb_req,
  input logic             wb_gnt,
  input logic [IW-1:0]    wb_idx
);

  assert_head_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_ok && alloc_cnt != '0) |=> head_o == $past(head_o) + IW'($past(alloc_cnt)));

  assert_head_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!alloc_ok || alloc_cnt == '0) |=> $stable(head_o));

  assert_tail_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !retire_vld |=> $stable(tail_o));

  assert_tail_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    retire_vld |=> (tail_o == $past(tail_o)) || (tail_o == $past(tail_o) + 1'b1));

  assert_xl_leave_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_req && xl_gnt && !agen_vld) |=> !(xl_req && xl_idx == $past(xl_idx)));

  assert_tag_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> $countones(mem_tag) == 1);

  assert_tag_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req |-> mem_tag == '0);

  assert_wb_leave_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && wb_gnt && !agen_vld) |=> !(wb_req && wb_idx == $past(wb_idx)));

endmodule

bind lsq_seq lsq_seq_chk #(.DEPTH(DEPTH), .ALLOC_W(ALLOC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .alloc_cnt  (alloc_cnt),
  .alloc_ok   (alloc_ok),
  .head_o     (head_o),
  .tail_o     (tail_o),
  .retire_vld (retire_vld),
  .agen_vld   (agen_vld),
  .xl_req     (xl_req),
  .xl_gnt     (xl_gnt),
  .xl_idx     (xl_idx),
  .mem_req    (mem_req),
  .mem_tag    (mem_tag),
  .wb_req     (wb_req),
  .wb_gnt     (wb_gnt),
  .wb_idx     (wb_idx)
);

// File: tb/lsq_seq_test.sv
`timescale 1ns/1ps
module lsq_seq_test;

  localparam int D   = 16;
  localparam int AW  = 2;
  localparam int IW  = 4;
  localparam int ACW = 2;
  localparam int NCYC = 20000;

  localparam int S_FREE = 0, S_AGEN = 1, S_VRDY = 2, S_XL = 3, S_PRDY = 4,
                 S_MOK = 5, S_FLT = 6, S_MISS = 7, S_DAT = 8, S_DONE = 9, S_ERR = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic [ACW-1:0] alloc_cnt;
  logic [AW-1:0] alloc_is_store;
  logic [AW*32-1:0] alloc_sdata;
  logic alloc_ok;
  logic [IW-1:0] head_o, tail_o;
  logic agen_vld;
  logic [IW-1:0] agen_idx;
  logic [31:0] agen_va;
  logic xl_req, xl_gnt;
  logic [IW-1:0] xl_idx;
  logic [31:0] xl_va;
  logic xl_rsp_vld;
  logic [IW-1:0] xl_rsp_idx;
  logic [2:0] xl_rsp_err;
  logic [31:0] xl_rsp_pa0, xl_rsp_pa1;
  logic xl_rsp_split;
  logic [D-1:0] dep_clr;
  logic mem_req, mem_gnt;
  logic [D-1:0] mem_tag;
  logic [31:0] mem_pa0, mem_pa1;
  logic mem_split, mem_store;
  logic [31:0] mem_wdata;
  logic mem_rsp_vld;
  logic [IW-1:0] mem_rsp_idx;
  logic mem_rsp_hit;
  logic [31:0] mem_rsp_data;
  logic [D-1:0] wake;
  logic wb_req, wb_gnt;
  logic [IW-1:0] wb_idx;
  logic [31:0] wb_data;
  logic retire_vld;

  always #5 clk = ~clk;

  lsq_seq uut (.*);

  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;

  // Behavioural reference state
  int m_st [D];
  logic [31:0] m_va [D], m_pa0 [D], m_pa1 [D], m_data [D];
  bit m_split [D], m_store [D];
  int m_head, m_tail, m_cnt;

  function automatic int oldest(int code);
    for (int k = 0; k < D; k++) begin
      int j;
      j = (m_tail + k) % D;
      if (m_st[j] == code) return j;
    end
    return -1;
  endfunction

  function automatic int any_in(int code);
    int s;
    s = $urandom_range(0, D-1);
    for (int k = 0; k < D; k++) begin
      int j;
      j = (s + k) % D;
      if (m_st[j] == code) return j;
    end
    return -1;
  endfunction

  function automatic bit model_ok();
    return (int'(alloc_cnt) <= AW) && (int'(alloc_cnt) <= D - m_cnt);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < D; i++) m_st[i] = S_FREE;
      m_head = 0; m_tail = 0; m_cnt = 0;
    end else begin
      int ns [D];
      int xj, mj, wj, n;
      bit ret, acc;
      xj = oldest(S_VRDY); mj = oldest(S_MOK); wj = oldest(S_DAT);
      acc = model_ok();
      n = acc ? int'(alloc_cnt) : 0;
      ret = retire_vld && (m_st[m_tail] == S_DONE || m_st[m_tail] == S_ERR);
      for (int i = 0; i < D; i++) begin
        int off;
        bit live;
        off = (i - m_head + D) % D;
        live = !(m_st[i] == S_FREE || m_st[i] == S_DONE || m_st[i] == S_ERR);
        ns[i] = m_st[i];
        if (m_st[i] == S_FREE && off < n) begin
          ns[i] = S_AGEN;
          m_store[i] = alloc_is_store[off];
          m_data[i] = alloc_sdata[off*32 +: 32];
        end else if (ret && i == m_tail) begin
          ns[i] = S_FREE;
        end else if (agen_vld && int'(agen_idx) == i && live) begin
          ns[i] = S_VRDY;
          m_va[i] = agen_va;
        end else begin
          case (m_st[i])
            S_VRDY: if (xl_gnt && xj == i) ns[i] = S_XL;
            S_XL: if (xl_rsp_vld && int'(xl_rsp_idx) == i) begin
              if (xl_rsp_err != 0) ns[i] = S_ERR;
              else begin
                ns[i] = S_PRDY;
                m_pa0[i] = xl_rsp_pa0; m_pa1[i] = xl_rsp_pa1; m_split[i] = xl_rsp_split;
              end
            end
            S_PRDY: if (dep_clr[i]) ns[i] = S_MOK;
            S_MOK: if (mem_gnt && mj == i) ns[i] = S_FLT;
            S_FLT: if (mem_rsp_vld && int'(mem_rsp_idx) == i) begin
              if (!mem_rsp_hit) ns[i] = S_MISS;
              else if (m_store[i]) ns[i] = S_DONE;
              else begin ns[i] = S_DAT; m_data[i] = mem_rsp_data; end
            end
            S_MISS: if (wake[i]) ns[i] = S_MOK;
            S_DAT: if (wb_gnt && wj == i) ns[i] = S_DONE;
            default: ;
          endcase
        end
      end
      for (int i = 0; i < D; i++) m_st[i] = ns[i];
      m_head = (m_head + n) % D;
      m_tail = (m_tail + (ret ? 1 : 0)) % D;
      m_cnt = m_cnt + n - (ret ? 1 : 0);
    end
  end

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int xj, mj, wj;
    chk("R2", "alloc_ok", 64'(alloc_ok), 64'(model_ok()));
    chk("R2", "head_o", 64'(head_o), 64'(m_head));
    chk("R3", "tail_o", 64'(tail_o), 64'(m_tail));
    xj = oldest(S_VRDY);
    chk("R4 R5 R6", "xl_req", 64'(xl_req), 64'(xj >= 0));
    chk("R4 R5 R6", "xl_idx", 64'(xl_idx), 64'(xj >= 0 ? xj : 0));
    chk("R4 R5 R6", "xl_va", 64'(xl_va), xj >= 0 ? 64'(m_va[xj]) : 64'(0));
    mj = oldest(S_MOK);
    chk("R7 R8 R9 R10", "mem_req", 64'(mem_req), 64'(mj >= 0));
    chk("R7 R8 R9 R10", "mem_tag", 64'(mem_tag), mj >= 0 ? (64'(1) << mj) : 64'(0));
    chk("R6 R8", "mem_pa0", 64'(mem_pa0), mj >= 0 ? 64'(m_pa0[mj]) : 64'(0));
    chk("R6 R8", "mem_pa1", 64'(mem_pa1), mj >= 0 ? 64'(m_pa1[mj]) : 64'(0));
    chk("R6 R8", "mem_split", 64'(mem_split), mj >= 0 ? 64'(m_split[mj]) : 64'(0));
    chk("R2 R8", "mem_store", 64'(mem_store), mj >= 0 ? 64'(m_store[mj]) : 64'(0));
    chk("R2 R8", "mem_wdata", 64'(mem_wdata),
        (mj >= 0 && m_store[mj]) ? 64'(m_data[mj]) : 64'(0));
    wj = oldest(S_DAT);
    chk("R9 R11", "wb_req", 64'(wb_req), 64'(wj >= 0));
    chk("R9 R11", "wb_idx", 64'(wb_idx), 64'(wj >= 0 ? wj : 0));
    chk("R9 R11", "wb_data", 64'(wb_data), wj >= 0 ? 64'(m_data[wj]) : 64'(0));
  endtask

  task automatic drive(int cyc);
    int p;
    alloc_cnt = ($urandom_range(0, 9) == 0) ? 2'd3 : ACW'($urandom_range(0, 2));
    alloc_is_store = AW'($urandom);
    alloc_sdata = {$urandom, $urandom};
    agen_vld = 1'($urandom_range(0, 1));
    p = oldest(S_AGEN);
    agen_idx = (p < 0 || $urandom_range(0, 4) == 0) ? IW'($urandom_range(0, D-1)) : IW'(p);
    agen_va = $urandom;
    xl_gnt = $urandom_range(0, 2) != 0;
    p = any_in(S_XL);
    if ($urandom_range(0, 7) == 0) p = $urandom_range(0, D-1);
    xl_rsp_vld = (p >= 0) && ($urandom_range(0, 1) == 1);
    xl_rsp_idx = IW'(p < 0 ? 0 : p);
    xl_rsp_err = ($urandom_range(0, 9) == 0) ? 3'($urandom_range(1, 7)) : 3'd0;
    xl_rsp_pa0 = $urandom;
    xl_rsp_pa1 = $urandom;
    xl_rsp_split = 1'($urandom);
    dep_clr = D'($urandom);
    mem_gnt = $urandom_range(0, 2) != 0;
    p = any_in(S_FLT);
    if ($urandom_range(0, 7) == 0) p = $urandom_range(0, D-1);
    mem_rsp_vld = (p >= 0) && ($urandom_range(0, 1) == 1);
    mem_rsp_idx = IW'(p < 0 ? 0 : p);
    mem_rsp_hit = 1'($urandom);
    mem_rsp_data = $urandom;
    wake = (cyc % 40 == 39) ? '1 : D'($urandom & $urandom & $urandom);
    wb_gnt = $urandom_range(0, 2) != 0;
    retire_vld = $urandom_range(0, 2) != 0;
  endtask

  task automatic idle_inputs();
    alloc_cnt = '0; alloc_is_store = '0; alloc_sdata = '0;
    agen_vld = 1'b0; agen_idx = '0; agen_va = '0;
    xl_gnt = 1'b0; xl_rsp_vld = 1'b0; xl_rsp_idx = '0; xl_rsp_err = '0;
    xl_rsp_pa0 = '0; xl_rsp_pa1 = '0; xl_rsp_split = 1'b0;
    dep_clr = '0; mem_gnt = 1'b0; mem_rsp_vld = 1'b0; mem_rsp_idx = '0;
    mem_rsp_hit = 1'b0; mem_rsp_data = '0; wake = '0; wb_gnt = 1'b0; retire_vld = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    idle_inputs();
    @(negedge clk);
    #1;
    // R1: reset state
    chk("R1", "head_o", 64'(head_o), 64'(0));
    chk("R1", "tail_o", 64'(tail_o), 64'(0));
    chk("R1", "xl_req", 64'(xl_req), 64'(0));
    chk("R1", "mem_req", 64'(mem_req), 64'(0));
    chk("R1", "wb_req", 64'(wb_req), 64'(0));
    alloc_cnt = 2'd2;
    #1;
    chk("R1", "alloc_ok", 64'(alloc_ok), 64'(1));
    alloc_cnt = '0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", "head_o after release", 64'(head_o), 64'(0));
    chk("R1", "xl_req after release", 64'(xl_req), 64'(0));
    for (int c = 0; c < NCYC; c++) begin
      @(negedge clk);
      drive(c);
      #1;
      compare_all();
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (NCYC + 1000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule